// File: doc/BRIEF.md
# Ring-Buffer Byte Mover with Half and Full Progress Events

This block is one channel that copies bytes between a serial peripheral's data register and a memory buffer. The peripheral raises a request for each byte it has ready, or for each byte it can accept. The channel then makes one memory access, answers with a one-cycle acknowledge, and moves its address pointer forward by one. Software sets a base address, a byte count, a direction and a mode, then sets the run bit.

The channel raises two progress events on a sticky status register. One fires when half of the programmed count has been moved. The other fires when the whole count has been moved. In ring mode the pointer and the remaining count reload by themselves after the last byte, and the channel keeps running. Software can therefore refill one half of the buffer while the other half is being moved, with no second channel. In one-shot mode the channel stops after the last byte. A faulting memory access also stops the channel and sets its own flag. Each flag can be read by polling, or enabled to drive a registered interrupt line.

Register map, selected by `reg_addr`: 0 control, 1 byte count, 2 base address, 3 status, 4 flag clear (write only), 5 remaining count (read only), 6 current address (read only). A read returns, on the next clock edge, the value at the offset that was sampled on that edge.

Top module: `cdma_channel`

## Requirements
- R1: Each peripheral request moves exactly one byte. The control register has a run bit (bit 0) and a direction bit (bit 2). With bit 2 clear, `per_rdata` is written to memory at the current address. With bit 2 set, the byte read from memory appears on `per_wdata` with `per_we` high. `per_ack` is a one-cycle pulse on the third rising edge after the request is first sampled.
- R2: Bytes go to consecutive addresses, starting at the base address (offset 2) and rising by one per byte.
- R3: The half flag (status bit 2) sets on the byte that brings the moved count to floor(N/2), where N is the count at offset 1. When floor(N/2) is 0, it sets together with the complete flag.
- R4: The complete flag (status bit 1) sets on the byte that brings the moved count to N.
- R5: With the ring bit (control bit 1) set, the remaining count and the address reload to N and to the base after the last byte, and the run bit stays set.
- R6: With the ring bit clear, the run bit clears after the last byte, and later requests get no acknowledge.
- R7: Flags stay set until a write of 1 to offset 4: bit 1 clears complete, bit 2 clears half, bit 3 clears error, bit 0 clears all three. A flag set in the same cycle as its clear stays set. Status bit 0 is the OR of bits 1 to 3.
- R8: `irq` goes high one cycle after any flag whose enable is set. The enables are control bit 3 for complete, bit 4 for half and bit 5 for error. Flags whose enable is clear do not raise `irq`.
- R9: If `mem_err` is returned for an access, the error flag (status bit 3) sets, the run bit clears, no acknowledge is given, and the remaining count and the address do not change.
- R10: Clearing the run bit stops the channel, including in ring mode. A byte whose memory access has already been issued still completes and is acknowledged.
- R11: Writes to offsets 1 and 2 are ignored while the run bit is set.
- R12: Setting the run bit while the count is zero leaves the channel stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| per_req | input | 1 | Peripheral byte request |
| per_rdata | input | 8 | Byte from the peripheral data register |
| per_ack | output | 1 | One-cycle acknowledge for a moved byte |
| per_we | output | 1 | Strobe for `per_wdata` (memory-to-peripheral direction) |
| per_wdata | output | 8 | Byte to the peripheral data register |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, one cycle after the access |
| mem_err | input | 1 | Access fault, one cycle after the access |
| irq | output | 1 | Registered interrupt |

## Verification
Two functions can fall in the same clock edge: a byte completing, which sets the half and complete flags, and a software write that clears those flags. The bench drives the clear write so that it is sampled on the very edge where a one-byte transfer sets both flags. It then expects the status to show both flags still set, and a second clear to remove them. A second overlap is a run-bit clear that lands while a memory access is in flight: that byte must still be written and acknowledged, and the next request must be refused.

// File: rtl/cdma_pkg.sv
package cdma_pkg;
  localparam int REG_AW = 3;
  localparam int REG_DW = 32;

  localparam logic [REG_AW-1:0] OFF_CTRL   = 3'd0;
  localparam logic [REG_AW-1:0] OFF_COUNT  = 3'd1;
  localparam logic [REG_AW-1:0] OFF_BASE   = 3'd2;
  localparam logic [REG_AW-1:0] OFF_STAT   = 3'd3;
  localparam logic [REG_AW-1:0] OFF_CLR    = 3'd4;
  localparam logic [REG_AW-1:0] OFF_REMAIN = 3'd5;
  localparam logic [REG_AW-1:0] OFF_CUR    = 3'd6;

  localparam int CTRL_W = 6;

  // run is bit 0, ring bit 1, dir bit 2, enables in bits 3..5
  typedef struct packed {
    logic ie_err;
    logic ie_half;
    logic ie_done;
    logic dir;
    logic ring;
    logic run;
  } ctrl_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACCESS,
    ST_RESP
  } xfer_st_e;
endpackage

// File: rtl/cdma_progress.sv
module cdma_progress #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  logic              ring,
  input  logic [CNT_W-1:0]  prog_cnt,
  input  logic [ADDR_W-1:0] base_addr,
  output logic [CNT_W-1:0]  remain,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              last_now,
  output logic              half_now
);
  localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

  logic [CNT_W-1:0] half_pt;
  logic [CNT_W-1:0] half_remain;

  assign half_pt     = prog_cnt >> 1;
  assign half_remain = prog_cnt - half_pt + CNT_ONE;
  assign last_now    = (remain == CNT_ONE);
  assign half_now    = (half_pt == '0) ? last_now : (remain == half_remain);

  always_ff @(posedge clk) begin
    if (rst) begin
      remain   <= '0;
      cur_addr <= '0;
    end else if (load) begin
      remain   <= prog_cnt;
      cur_addr <= base_addr;
    end else if (step) begin
      if (last_now && ring) begin
        remain   <= prog_cnt;
        cur_addr <= base_addr;
      end else begin
        remain   <= remain - CNT_ONE;
        cur_addr <= cur_addr + ADDR_ONE;
      end
    end
  end

  // R5: after the last byte in ring mode, pointer and count are back at the start
  a_r5_ring_reload: assert property (@(posedge clk) disable iff (rst)
    (step && last_now && ring) |=> (remain == prog_cnt && cur_addr == base_addr));

  // R2: a byte that is not the last moves the pointer up by one
  a_r2_addr_step: assert property (@(posedge clk) disable iff (rst)
    (step && !last_now && !load) |=> (cur_addr == $past(cur_addr) + ADDR_ONE));
endmodule

// File: rtl/cdma_xfer_fsm.sv
module cdma_xfer_fsm
  import cdma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              dir,
  input  logic              ring,
  input  logic              last_now,
  input  logic              half_now,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic              per_req,
  input  logic [DATA_W-1:0] per_rdata,
  output logic              per_ack,
  output logic              per_we,
  output logic [DATA_W-1:0] per_wdata,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_err,
  output logic              step,
  output logic              ev_done,
  output logic              ev_half,
  output logic              ev_err
);
  xfer_st_e st_q;
  logic     resp_ok;

  assign resp_ok = (st_q == ST_RESP) && !mem_err;
  assign step    = resp_ok;
  assign ev_done = resp_ok && last_now;
  assign ev_half = resp_ok && half_now;
  assign ev_err  = (st_q == ST_RESP) && mem_err;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      per_ack   <= 1'b0;
      per_we    <= 1'b0;
      per_wdata <= '0;
      mem_en    <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      per_ack <= 1'b0;
      per_we  <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (run && per_req) begin
            mem_en    <= 1'b1;
            mem_we    <= !dir;
            mem_addr  <= cur_addr;
            mem_wdata <= per_rdata;
            st_q      <= ST_ACCESS;
          end
        end
        ST_ACCESS: begin
          mem_en <= 1'b0;
          mem_we <= 1'b0;
          st_q   <= ST_RESP;
        end
        ST_RESP: begin
          st_q <= ST_IDLE;
          if (!mem_err) begin
            per_ack <= 1'b1;
            if (dir) begin
              per_we    <= 1'b1;
              per_wdata <= mem_rdata;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R1: acknowledge lasts one cycle
  a_r1_ack_pulse: assert property (@(posedge clk) disable iff (rst)
    per_ack |=> !per_ack);

  // R1: every acknowledge follows a memory access two cycles earlier
  a_r1_ack_has_access: assert property (@(posedge clk) disable iff (rst)
    per_ack |-> $past(mem_en, 2));

  // R6: one-shot mode drops the run bit after the last byte
  a_r6_oneshot_stop: assert property (@(posedge clk) disable iff (rst)
    (ev_done && !ring) |=> !run);

  // R9: a fault stops the channel and is not acknowledged
  a_r9_fault_stop: assert property (@(posedge clk) disable iff (rst)
    ev_err |=> (!run && !per_ack));
endmodule

// File: rtl/cdma_regs.sv
module cdma_regs
  import cdma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  prog_cnt,
  output logic [ADDR_W-1:0] base_addr,
  output logic              load,
  input  logic [CNT_W-1:0]  remain,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic              ev_done,
  input  logic              ev_half,
  input  logic              ev_err,
  output logic              irq
);
  ctrl_t             ctrl_q;
  logic [CNT_W-1:0]  prog_q;
  logic [ADDR_W-1:0] base_q;
  logic              f_done, f_half, f_err;
  logic              wr_ctrl, wr_clr;
  logic              clr_done, clr_half, clr_err;
  logic [REG_DW-1:0] rd_mux;

  assign wr_ctrl  = reg_wr && (reg_addr == OFF_CTRL);
  assign wr_clr   = reg_wr && (reg_addr == OFF_CLR);
  assign clr_done = wr_clr && (reg_wdata[0] || reg_wdata[1]);
  assign clr_half = wr_clr && (reg_wdata[0] || reg_wdata[2]);
  assign clr_err  = wr_clr && (reg_wdata[0] || reg_wdata[3]);
  assign load     = wr_ctrl && reg_wdata[0] && !ctrl_q.run && (prog_q != '0);

  assign ctrl      = ctrl_q;
  assign prog_cnt  = prog_q;
  assign base_addr = base_q;

  always_comb begin
    rd_mux = '0;
    unique case (reg_addr)
      OFF_CTRL:   rd_mux[CTRL_W-1:0] = ctrl_q;
      OFF_COUNT:  rd_mux[CNT_W-1:0]  = prog_q;
      OFF_BASE:   rd_mux[ADDR_W-1:0] = base_q;
      OFF_STAT:   rd_mux[3:0]        = {f_err, f_half, f_done, f_err | f_half | f_done};
      OFF_REMAIN: rd_mux[CNT_W-1:0]  = remain;
      OFF_CUR:    rd_mux[ADDR_W-1:0] = cur_addr;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      prog_q    <= '0;
      base_q    <= '0;
      f_done    <= 1'b0;
      f_half    <= 1'b0;
      f_err     <= 1'b0;
      irq       <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q     <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
        ctrl_q.run <= reg_wdata[0] && (ctrl_q.run || prog_q != '0);
      end
      if (ev_err || (ev_done && !ctrl_q.ring))
        ctrl_q.run <= 1'b0;
      if (reg_wr && reg_addr == OFF_COUNT && !ctrl_q.run)
        prog_q <= reg_wdata[CNT_W-1:0];
      if (reg_wr && reg_addr == OFF_BASE && !ctrl_q.run)
        base_q <= reg_wdata[ADDR_W-1:0];
      f_done    <= (f_done && !clr_done) || ev_done;
      f_half    <= (f_half && !clr_half) || ev_half;
      f_err     <= (f_err  && !clr_err)  || ev_err;
      irq       <= (f_done && ctrl_q.ie_done) || (f_half && ctrl_q.ie_half) ||
                   (f_err && ctrl_q.ie_err);
      reg_rdata <= rd_mux;
    end
  end

  // R11: count and base hold still while the channel runs
  a_r11_locked: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q.run && $past(ctrl_q.run)) |-> ($stable(prog_q) && $stable(base_q)));

  // R7: a flag is not lost without a clear
  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    (f_done && !clr_done) |=> f_done);

  // R12: a zero count never starts the channel
  a_r12_no_zero_run: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q.run && prog_q == '0 && !(reg_wr && reg_addr == OFF_COUNT)) |=> !ctrl_q.run);
endmodule

// File: rtl/cdma_channel.sv
module cdma_channel
  import cdma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  input  logic              per_req,
  input  logic [DATA_W-1:0] per_rdata,
  output logic              per_ack,
  output logic              per_we,
  output logic [DATA_W-1:0] per_wdata,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_err,
  output logic              irq
);
  ctrl_t             ctrl;
  logic [CNT_W-1:0]  prog_cnt, remain;
  logic [ADDR_W-1:0] base_addr, cur_addr;
  logic              load, step, last_now, half_now;
  logic              ev_done, ev_half, ev_err;

  cdma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ctrl(ctrl), .prog_cnt(prog_cnt), .base_addr(base_addr), .load(load),
    .remain(remain), .cur_addr(cur_addr),
    .ev_done(ev_done), .ev_half(ev_half), .ev_err(ev_err), .irq(irq)
  );

  cdma_progress #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_prog (
    .clk(clk), .rst(rst), .load(load), .step(step), .ring(ctrl.ring),
    .prog_cnt(prog_cnt), .base_addr(base_addr),
    .remain(remain), .cur_addr(cur_addr), .last_now(last_now), .half_now(half_now)
  );

  cdma_xfer_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst(rst), .run(ctrl.run), .dir(ctrl.dir), .ring(ctrl.ring),
    .last_now(last_now), .half_now(half_now), .cur_addr(cur_addr),
    .per_req(per_req), .per_rdata(per_rdata), .per_ack(per_ack),
    .per_we(per_we), .per_wdata(per_wdata),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_err(mem_err),
    .step(step), .ev_done(ev_done), .ev_half(ev_half), .ev_err(ev_err)
  );
endmodule

// File: tb/tb_cdma_channel.sv
module tb_cdma_channel;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        per_req = 1'b0;
  logic [7:0]  per_rdata = '0;
  logic        per_ack, per_we;
  logic [7:0]  per_wdata;
  logic        mem_en, mem_we;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic        mem_err = 1'b0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;
  logic [7:0] bmem [0:255];

  always #5 clk = ~clk;

  cdma_channel dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .per_req(per_req), .per_rdata(per_rdata), .per_ack(per_ack),
    .per_we(per_we), .per_wdata(per_wdata), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_err(mem_err), .irq(irq)
  );

  // memory model: addresses at 0xF000 and above fault
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_addr >= 16'hF000) mem_err <= 1'b1;
      else begin
        mem_err <= 1'b0;
        if (mem_we) bmem[mem_addr[7:0]] <= mem_wdata;
        mem_rdata <= bmem[mem_addr[7:0]];
      end
    end else mem_err <= 1'b0;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic xfer(input logic [7:0] d, output bit acked, output bit we, output logic [7:0] wd);
    @(negedge clk);
    per_req = 1'b1; per_rdata = d; acked = 0; we = 0; wd = '0;
    for (int i = 0; i < 8 && !acked; i++) begin
      @(negedge clk);
      if (per_ack) begin acked = 1; we = per_we; wd = per_wdata; end
    end
    per_req = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(3'd0, v); chk("R1 reset ctrl", v, 0);
    rd(3'd3, v); chk("R7 reset status", v, 0);
    chk("R8 reset irq", irq, 0);
    chk("R1 reset ack", per_ack, 0);
  endtask

  task automatic t_to_mem_odd();
    logic [31:0] v; bit a, w; logic [7:0] wd;
    wr(3'd1, 5); wr(3'd2, 16'h0020); wr(3'd0, 32'h11);
    xfer(8'hA0, a, w, wd); chk("R1 ack byte0", a, 1);
    rd(3'd3, v); chk("R3 no half after 1 of 5", v, 0);
    wr(3'd1, 9); rd(3'd1, v); chk("R11 count locked", v, 5);
    wr(3'd2, 16'h0099); rd(3'd2, v); chk("R11 base locked", v, 16'h0020);
    xfer(8'hA1, a, w, wd);
    @(negedge clk); chk("R8 irq on half", irq, 1);
    rd(3'd3, v); chk("R3 half after 2 of 5", v, 5);
    for (int i = 2; i < 5; i++) xfer(8'hA0 + 8'(i), a, w, wd);
    rd(3'd3, v); chk("R4 complete after 5", v, 7);
    for (int i = 0; i < 5; i++) chk("R2 consecutive bytes", bmem[8'h20 + 8'(i)], 8'hA0 + 8'(i));
    rd(3'd0, v); chk("R6 run cleared", v, 32'h10);
    xfer(8'hEE, a, w, wd); chk("R6 no ack when stopped", a, 0);
    chk("R6 memory untouched", bmem[8'h25], 8'h00);
    wr(3'd4, 1);
  endtask

  task automatic t_to_per();
    logic [31:0] v; bit a, w; logic [7:0] wd;
    wr(3'd1, 3); wr(3'd2, 16'h0040); wr(3'd0, 32'h0D);
    xfer(8'h00, a, w, wd);
    chk("R1 per_we on read", w, 1); chk("R1 byte0 to peripheral", wd, 8'h11);
    rd(3'd3, v); chk("R3 half after 1 of 3", v, 5);
    @(negedge clk); chk("R8 masked half no irq", irq, 0);
    xfer(8'h00, a, w, wd); chk("R2 byte1 to peripheral", wd, 8'h22);
    xfer(8'h00, a, w, wd); chk("R2 byte2 to peripheral", wd, 8'h33);
    @(negedge clk); chk("R8 irq on complete", irq, 1);
    wr(3'd4, 32'h2); rd(3'd3, v); chk("R7 clear complete only", v, 5);
    @(negedge clk); chk("R8 irq drops after clear", irq, 0);
    wr(3'd4, 1);
  endtask

  task automatic t_ring();
    logic [31:0] v; bit a, w; logic [7:0] wd;
    wr(3'd1, 4); wr(3'd2, 16'h0060); wr(3'd0, 32'h03);
    for (int i = 0; i < 4; i++) xfer(8'hC0 + 8'(i), a, w, wd);
    rd(3'd3, v); chk("R4 ring complete", v, 7);
    rd(3'd5, v); chk("R5 remain reloaded", v, 4);
    rd(3'd6, v); chk("R5 address reloaded", v, 16'h0060);
    rd(3'd0, v); chk("R5 still running", v, 3);
    chk("R8 no irq when masked", irq, 0);
    wr(3'd4, 1);
    xfer(8'hC4, a, w, wd); xfer(8'hC5, a, w, wd);
    chk("R5 wrap write 0", bmem[8'h60], 8'hC4);
    chk("R5 wrap write 1", bmem[8'h61], 8'hC5);
    rd(3'd3, v); chk("R3 half in second lap", v, 5);
    wr(3'd0, 0);
    xfer(8'hDD, a, w, wd); chk("R10 ring stopped", a, 0);
    chk("R10 no write after stop", bmem[8'h62], 8'hC2);
    wr(3'd4, 1);
  endtask

  task automatic t_stop_inflight();
    logic [31:0] v;
    wr(3'd1, 4); wr(3'd2, 16'h0070); wr(3'd0, 32'h03);
    @(negedge clk); per_req = 1'b1; per_rdata = 8'h5C;
    @(negedge clk); reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 0;
    @(negedge clk); reg_wr = 1'b0;
    @(negedge clk); chk("R10 in-flight byte acked", per_ack, 1); per_req = 1'b0;
    chk("R10 in-flight byte written", bmem[8'h70], 8'h5C);
    rd(3'd5, v); chk("R10 count advanced once", v, 3);
    wr(3'd4, 1);
  endtask

  task automatic t_fault();
    logic [31:0] v; bit a, w; logic [7:0] wd;
    wr(3'd1, 2); wr(3'd2, 16'hF000); wr(3'd0, 32'h21);
    xfer(8'h77, a, w, wd); chk("R9 no ack on fault", a, 0);
    rd(3'd3, v); chk("R9 error flag", v, 9);
    rd(3'd0, v); chk("R9 run cleared", v, 32'h20);
    rd(3'd5, v); chk("R9 remain unchanged", v, 2);
    rd(3'd6, v); chk("R9 address unchanged", v, 16'hF000);
    chk("R8 irq on error", irq, 1);
    wr(3'd4, 32'h8); rd(3'd3, v); chk("R7 error cleared", v, 0);
  endtask

  task automatic t_zero();
    logic [31:0] v;
    wr(3'd1, 0); wr(3'd0, 1);
    rd(3'd0, v); chk("R12 zero count no start", v, 0);
  endtask

  task automatic t_set_vs_clear();
    logic [31:0] v;
    wr(3'd1, 1); wr(3'd2, 16'h0080); wr(3'd0, 32'h01);
    @(negedge clk); per_req = 1'b1; per_rdata = 8'h3E;
    @(negedge clk);
    @(negedge clk); reg_wr = 1'b1; reg_addr = 3'd4; reg_wdata = 1;
    @(negedge clk); reg_wr = 1'b0;
    chk("R1 ack for one-byte run", per_ack, 1); per_req = 1'b0;
    rd(3'd3, v); chk("R7 set wins over clear, R3 half with complete", v, 7);
    wr(3'd4, 1); rd(3'd3, v); chk("R7 later clear works", v, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) bmem[i] = 8'h00;
    bmem[8'h40] = 8'h11; bmem[8'h41] = 8'h22; bmem[8'h42] = 8'h33;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_to_mem_odd();
    t_to_per();
    t_ring();
    t_stop_inflight();
    t_fault();
    t_zero();
    t_set_vs_clear();
    if (!done_flag) begin
      done_flag = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule